// File: doc/BRIEF.md
# Real-Time Clock Divider, Update Timing and Periodic Rate Generator

This block sits between a 32.768 kHz time-base enable and the calendar counter of a real-time clock. It owns the 15-bit prescaler chain. From that chain it makes three things: the once-per-second update pulse that advances the time, the update-in-progress status bit, and a programmable periodic event.

Software controls it through two registers. The first is an 8-bit control word. Its divider-mode field chooses between running, holding in reset and stopping. Its rate field chooses the periodic frequency. The second register is a set of level bits: a time-set hold that freezes updates while software loads the time, and two interrupt enables.

Two event flags are kept: the periodic flag and the update-ended flag. Both are sticky and both are cleared by a read strobe. The interrupt line is the OR of each flag gated by its enable.

Top module: `rtc_tick_ctrl`

## Requirements
- R1: While the divider-mode field is 110 or 111, the prescaler is held at its half-second preset. No update pulse is issued and the update-in-progress bit stays 0.
- R2: After the divider-mode field is written with 010, the first update pulse appears exactly 16384 time-base enables later, which is half a second.
- R3: The update-in-progress bit is 1 for exactly 8 time-base enables, ending at the enable that issues the update. It is 0 at all other times.
- R4: The update pulse lasts a single clock cycle. While the divider runs, one pulse is issued every 32768 enables.
- R5: While the time-set hold is 1, update pulses, the update-in-progress bit and the update-ended flag are all suppressed. Once the hold is cleared, the next one-second boundary issues an update again.
- R6: The periodic period in time-base enables is 2^(n-1) for rate code n from 3 to 15. Code 1 gives 128 and code 2 gives 256.
- R7: Rate code 0 produces no periodic event.
- R8: The interrupt is 1 exactly when (periodic flag AND periodic enable) OR (update-ended flag AND update enable).
- R9: Both flags stay set until a flag-read strobe clears them. If a new event arrives in the same cycle as the strobe, the set wins.
- R10: A new rate code takes effect from the next boundary of the new period. After a code-15 event, switching to code 13 gives the next event 4096 enables later.
- R11: In the control word, bits [6:4] are the divider-mode field and bits [3:0] are the rate field. Bit 7 is ignored. The reset value is divider mode 111 with rate code 0.
- R12: The update-ended flag is set in the same cycle that the update pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| ctl_a_we | input | 1 | Write strobe for the control word |
| ctl_a_wd | input | 8 | Control word data: [6:4] divider mode, [3:0] rate code |
| set_hold | input | 1 | Time-set hold; freezes updates while 1 |
| pie | input | 1 | Periodic interrupt enable |
| uie | input | 1 | Update-ended interrupt enable |
| flag_rd | input | 1 | Flag read strobe; clears both flags |
| upd_tick | output | 1 | One-cycle update pulse to the time counter |
| uip | output | 1 | Update-in-progress status |
| pf | output | 1 | Periodic flag |
| uf | output | 1 | Update-ended flag |
| irq | output | 1 | Interrupt request |

## Verification
The divider mode is driven through three patterns: held in reset, held with bit 7 set, and released. These separate a working preset and hold from a prescaler that free-runs, and a decoder that looks at bit 7 from one that ignores it. The release is followed cycle by cycle, so an off-by-one in the half-second preset or in the width of the update-in-progress window shows up as a shifted edge. A full second with the time-set hold raised, followed by a second with it cleared, distinguishes proper gating from gating that never recovers. The rate field is walked through a table of codes and then alternated between 15 and 13. This exposes a wrong tap for any one code, as well as a period that fails to change at the next boundary.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

   typedef enum logic [1:0] {
      DIV_RUN   = 2'd0,
      DIV_RESET = 2'd1,
      DIV_STOP  = 2'd2
   } div_mode_e;

   // divider-mode field decode
   function automatic div_mode_e decode_mode(input logic [2:0] dv);
      if (dv == 3'b010)          return DIV_RUN;
      else if (dv[2:1] == 2'b11) return DIV_RESET;
      else                       return DIV_STOP;
   endfunction

   // prescaler tap for a rate code; 0 means no periodic output
   function automatic logic [4:0] rate_shift(input logic [3:0] rs);
      case (rs)
         4'd0:    return 5'd0;
         4'd1:    return 5'd7;
         4'd2:    return 5'd8;
         default: return {1'b0, rs} - 5'd1;
      endcase
   endfunction

endpackage

// File: rtl/rtc_div_core.sv
module rtc_div_core
   import rtc_ctl_pkg::*;
#(
   parameter int DIV_W   = 15,
   parameter int UIP_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_en,
   input  div_mode_e        mode,
   input  logic             set_hold,
   output logic [DIV_W-1:0] cnt,
   output logic             tick_now,
   output logic             upd_tick,
   output logic             uip
);

   localparam logic [DIV_W-1:0] CNT_MAX  = '1;
   localparam logic [DIV_W-1:0] CNT_HALF = DIV_W'(1) << (DIV_W - 1);
   localparam logic [DIV_W-1:0] UIP_FROM = CNT_MAX - DIV_W'(UIP_LEN - 1);

   logic run;
   assign run      = (mode == DIV_RUN);
   assign tick_now = run && tb_en && !set_hold && (cnt == CNT_MAX);
   assign uip      = run && !set_hold && (cnt >= UIP_FROM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= CNT_HALF;
         upd_tick <= 1'b0;
      end else begin
         upd_tick <= tick_now;
         if (mode == DIV_RESET)  cnt <= CNT_HALF;
         else if (run && tb_en)  cnt <= cnt + 1'b1;
      end
   end

   // enables counted while the in-progress bit stays high
   logic [DIV_W-1:0] uip_en_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              uip_en_cnt <= '0;
      else if (!uip)           uip_en_cnt <= '0;
      else if (tb_en)          uip_en_cnt <= uip_en_cnt + 1'b1;
   end

   // R1
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DIV_RESET) |=> !upd_tick);
   // R3
   uip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uip_en_cnt <= DIV_W'(UIP_LEN));
   // R4
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_tick |=> !upd_tick);

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
   import rtc_ctl_pkg::*;
#(
   parameter int DIV_W = 15
) (
   input  logic             tb_en,
   input  logic             run,
   input  logic [3:0]       rs,
   input  logic [DIV_W-1:0] cnt,
   output logic             per_hit
);

   logic [4:0]       shift;
   logic [DIV_W-1:0] mask;

   always_comb begin
      shift   = rate_shift(rs);
      mask    = (DIV_W'(1) << shift) - DIV_W'(1);
      per_hit = tb_en && run && (shift != 5'd0) && ((cnt & mask) == mask);
   end

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pf,
   input  logic set_uf,
   input  logic clr,
   input  logic pie,
   input  logic uie,
   output logic pf,
   output logic uf,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf <= 1'b0;
         uf <= 1'b0;
      end else begin
         pf <= set_pf | (pf & ~clr);
         uf <= set_uf | (uf & ~clr);
      end
   end

   assign irq = (pf & pie) | (uf & uie);

   // R9
   pf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_pf |=> pf);
   // R9
   uf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_uf |=> uf);

endmodule

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
   import rtc_ctl_pkg::*;
#(
   parameter int DIV_W   = 15,
   parameter int UIP_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tb_en,
   input  logic       ctl_a_we,
   input  logic [7:0] ctl_a_wd,
   input  logic       set_hold,
   input  logic       pie,
   input  logic       uie,
   input  logic       flag_rd,
   output logic       upd_tick,
   output logic       uip,
   output logic       pf,
   output logic       uf,
   output logic       irq
);

   generate
      if (DIV_W < 15) begin : g_bad_width
         $error("DIV_W must cover the 2 Hz rate tap");
      end
      if (UIP_LEN < 1 || UIP_LEN >= (1 << (DIV_W - 1))) begin : g_bad_uip
         $error("UIP_LEN must fit inside the second half of the prescaler");
      end
   endgenerate

   logic [2:0] dv_q;
   logic [3:0] rs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q <= 3'b111;
         rs_q <= 4'd0;
      end else if (ctl_a_we) begin
         dv_q <= ctl_a_wd[6:4];
         rs_q <= ctl_a_wd[3:0];
      end
   end

   div_mode_e        mode;
   logic [DIV_W-1:0] cnt;
   logic             tick_now;
   logic             per_hit;

   assign mode = decode_mode(dv_q);

   rtc_div_core #(.DIV_W(DIV_W), .UIP_LEN(UIP_LEN)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_en    (tb_en),
      .mode     (mode),
      .set_hold (set_hold),
      .cnt      (cnt),
      .tick_now (tick_now),
      .upd_tick (upd_tick),
      .uip      (uip)
   );

   rtc_rate_tap #(.DIV_W(DIV_W)) u_rate (
      .tb_en   (tb_en),
      .run     (mode == DIV_RUN),
      .rs      (rs_q),
      .cnt     (cnt),
      .per_hit (per_hit)
   );

   rtc_flag_unit u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_pf (per_hit),
      .set_uf (tick_now),
      .clr    (flag_rd),
      .pie    (pie),
      .uie    (uie),
      .pf     (pf),
      .uf     (uf),
      .irq    (irq)
   );

   // R5
   set_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_tick |-> $past(!set_hold));
   // R12
   uf_with_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_tick |-> uf);

endmodule

// File: tb/test_rtc_tick_ctrl.sv
module test_rtc_tick_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NRATE = 6;
   localparam int RATE_CODE [NRATE] = '{1, 2, 3, 6, 9, 13};
   localparam int RATE_GAP  [NRATE] = '{128, 256, 4, 32, 256, 4096};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tb_en = 1'b1;
   logic       ctl_a_we = 1'b0;
   logic [7:0] ctl_a_wd = 8'h00;
   logic       set_hold = 1'b0;
   logic       pie = 1'b0;
   logic       uie = 1'b0;
   logic       flag_rd = 1'b0;
   logic       upd_tick, uip, pf, uf, irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rtc_tick_ctrl i_rtc_tick_ctrl (
      .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .ctl_a_we(ctl_a_we),
      .ctl_a_wd(ctl_a_wd), .set_hold(set_hold), .pie(pie), .uie(uie),
      .flag_rd(flag_rd), .upd_tick(upd_tick), .uip(uip), .pf(pf),
      .uf(uf), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_a(input logic [7:0] v);
      @(negedge clk); ctl_a_we = 1'b1; ctl_a_wd = v;
      @(posedge clk); #1; ctl_a_we = 1'b0;
   endtask

   task automatic clr_flags();
      @(negedge clk); flag_rd = 1'b1;
      @(posedge clk); #1; flag_rd = 1'b0;
   endtask

   task automatic wait_pf(output int t);
      int n = 0;
      t = -1;
      while (n < 40000) begin
         @(posedge clk); #1; n++;
         if (pf) begin t = cyc; break; end
      end
   endtask

   task automatic quiet_run(input int n, output int ticks, output int uips);
      ticks = 0; uips = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         if (upd_tick) ticks++;
         if (uip) uips++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ticks, uips, t1, t2, bad_uip, bad_tick;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk(!upd_tick && !uip && !pf && !uf && !irq, "R11 reset outputs",
          {upd_tick, uip, pf, uf, irq}, 0);
      rst_n = 1'b1;

      // R11 reset value holds the divider
      quiet_run(2000, ticks, uips);
      chk(ticks == 0 && uips == 0, "R11 reset divider held", ticks + uips, 0);
      // R1 explicit hold with bit 7 set (ignored)
      wr_a(8'hF6);
      quiet_run(2000, ticks, uips);
      chk(ticks == 0 && uips == 0, "R1 divider reset no update", ticks + uips, 0);

      // R2/R3 release, bit 7 set must be ignored (R11)
      uie = 1'b1;
      wr_a(8'hA6);
      bad_uip = 0; bad_tick = 0;
      for (int k = 1; k <= 16384; k++) begin
         @(posedge clk); #1;
         if (uip != (k >= 16376 && k <= 16383)) bad_uip++;
         if (upd_tick != (k == 16384)) bad_tick++;
      end
      chk(bad_tick == 0, "R2 first update after half second", bad_tick, 0);
      chk(bad_uip == 0, "R3 uip window 8 enables", bad_uip, 0);
      chk(uf == 1'b1, "R12 uf with update", uf, 1);
      chk(irq == 1'b1, "R8 irq from uf and uie", irq, 1);

      // R5 hold across one full second
      @(negedge clk); set_hold = 1'b1; flag_rd = 1'b1;
      bad_uip = 0; bad_tick = 0;
      for (int k = 1; k <= 32768; k++) begin
         @(posedge clk); #1; flag_rd = 1'b0;
         if (uip) bad_uip++;
         if (upd_tick) bad_tick++;
      end
      chk(bad_tick == 0 && bad_uip == 0, "R5 hold suppresses update",
          bad_tick + bad_uip, 0);
      chk(uf == 1'b0, "R9 uf cleared and R5 not set under hold", uf, 0);
      chk(irq == 1'b0, "R8 irq low with flags clear", irq, 0);

      // R5 release; R4 one pulse per second
      @(negedge clk); set_hold = 1'b0;
      bad_uip = 0; bad_tick = 0;
      for (int k = 1; k <= 32768; k++) begin
         @(posedge clk); #1;
         if (uip != (k >= 32760 && k <= 32767)) bad_uip++;
         if (upd_tick != (k == 32768)) bad_tick++;
      end
      chk(bad_tick == 0, "R4 R5 update resumes at boundary", bad_tick, 0);
      chk(bad_uip == 0, "R3 uip window after release", bad_uip, 0);
      uie = 1'b0;
      clr_flags();

      // R6 rate table
      for (int i = 0; i < NRATE; i++) begin
         wr_a(8'h20 | 8'(RATE_CODE[i]));
         clr_flags();
         wait_pf(t1);
         clr_flags();
         wait_pf(t2);
         chk(t1 >= 0 && t2 - t1 == RATE_GAP[i], $sformatf("R6 code %0d period", RATE_CODE[i]),
             t2 - t1, RATE_GAP[i]);
      end

      // R8 periodic enable gating
      chk(pf == 1'b1 && irq == 1'b0, "R8 irq masked without pie", irq, 0);
      @(negedge clk); pie = 1'b1; #1;
      chk(irq == 1'b1, "R8 irq with pf and pie", irq, 1);
      @(negedge clk); pie = 1'b0;

      // R7 code 0
      wr_a(8'h20);
      clr_flags();
      repeat (1000) @(posedge clk);
      #1;
      chk(pf == 1'b0, "R7 code 0 no periodic", pf, 0);

      // R6 code 15, then R10 switch to 13 and back
      wr_a(8'h2F);
      clr_flags();
      wait_pf(t1);
      clr_flags();
      wait_pf(t2);
      chk(t1 >= 0 && t2 - t1 == 16384, "R6 code 15 period", t2 - t1, 16384);
      clr_flags();
      wr_a(8'h2D);
      wait_pf(t1);
      chk(t1 >= 0 && t1 - t2 == 4096, "R10 switch to 13", t1 - t2, 4096);
      clr_flags();
      wr_a(8'h2F);
      wait_pf(t2);
      chk(t2 >= 0 && t2 - t1 > 0 && t2 - t1 <= 16384 && (t2 - t1) % 4096 == 0,
          "R10 switch back to 15", t2 - t1, 16384);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule